// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Fabric

This block is an N-by-N multistage switching fabric for fixed-size cells. It is built from log2(N) columns of two-by-two exchange elements, each column holding N/2 elements, with a perfect-shuffle link pattern in front of every column. Every input port may offer a cell in every clock slot; a cell carries a valid flag, the number of the output port it wants, and a payload. No central controller is involved: at the ingress the fabric turns the destination number into a routing tag by reversing its bits, and each element decides locally, from one tag bit, whether a cell leaves on its upper or its lower output.

Each column is registered, so a cell moves one column per slot and emerges log2(N) slots after it was offered. There is no internal buffering. When two cells in the same element want the same output, the cell on the element's upper input goes on and the other is discarded; a saturating counter records every discarded cell. Each output port presents a valid flag, the payload, and the destination field the cell was sent with.

Top module: `omega_fabric`

## Requirements
- R1: While reset is high, and in the slots after it until new cells have had time to cross the fabric, every out_valid bit is 0; reset also clears drop_count to 0.
- R2: A cell offered at an input in a given slot appears at an output exactly log2(N) slots later (3 slots for N=8).
- R3: A delivered cell appears on the output whose index equals its destination field, with its payload and destination field unchanged, whichever input it entered on.
- R4: When all inputs offer cells in every slot under a cyclic-shift pattern (input i to output (i+c) mod N), every cell is delivered and drop_count does not move.
- R5: On contention the cell from the element's upper input survives and the other is discarded. The upper input of element e in a column is shuffled link 2e, and shuffled link k carries the previous column's link obtained by rotating k right by one bit; for N=8, inputs 0 and 4 therefore meet in element 0 of the first column and input 0 wins.
- R6: drop_count rises by exactly the number of cells discarded, summed over all columns.
- R7: drop_count saturates at 2^CNT_W-1 and stays there until reset.
- R8: An input whose in_valid bit is 0 has no effect: it yields no output cell and no drop, whatever its destination field holds.
- R9: The routing tag is the destination with its bits reversed, and column s (counting from 0 at the inputs) uses tag bit s, sending the cell up on 0 and down on 1; two cells whose destinations share their most significant bit collide in the first column if they meet there, even when their destinations differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Per-input cell present flag |
| in_dest | input | N*log2(N) | Per-input destination port number, input i at bits [i*log2(N) +: log2(N)] |
| in_payload | input | N*PW | Per-input payload, input i at bits [i*PW +: PW] |
| out_valid | output | N | Per-output cell present flag |
| out_dest | output | N*log2(N) | Destination field of the cell on each output |
| out_payload | output | N*PW | Payload of the cell on each output |
| drop_count | output | CNT_W | Saturating count of discarded cells |

## Verification
The bench builds the fabric with N=8, an 8-bit payload, and a 4-bit drop counter. The eight-port size gives three columns, so shuffle wiring, all three tag bits, and contention in every column are exercised, including the case where input 0 wins at each column against a full fan-in to one output. The narrow counter lets a few slots of full fan-in reach the saturation value of 15, which a wide counter would never reach in a short run.

// File: rtl/fab_pkg.sv
package fab_pkg;

    // Default fabric dimensions
    localparam int unsigned FAB_PORTS_DEF = 8;
    localparam int unsigned FAB_PAY_DEF   = 8;
    localparam int unsigned FAB_CNT_DEF   = 16;

    // Element output choice taken from one tag bit
    typedef enum logic {
        ROUTE_UPPER = 1'b0,
        ROUTE_LOWER = 1'b1
    } route_e;

    // Perfect shuffle: shuffled link k is fed by the previous column's
    // link whose index is k rotated right by one bit (w bits wide).
    function automatic int unsigned shuffle_src(int unsigned k, int unsigned w);
        return (k >> 1) | ((k & 1) << (w - 1));
    endfunction

endpackage

// File: rtl/fab_elem.sv
module fab_elem #(
    parameter int unsigned AW  = 3,
    parameter int unsigned PW  = 8,
    parameter int unsigned STG = 0
) (
    input  logic [2*AW+PW:0] in_hi,
    input  logic [2*AW+PW:0] in_lo,
    output logic [2*AW+PW:0] out_hi,
    output logic [2*AW+PW:0] out_lo,
    output logic             drop
);
    import fab_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] tag;
        logic [AW-1:0] dest;
        logic [PW-1:0] pay;
    } cell_t;

    cell_t  a_c, b_c, oh_c, ol_c;
    route_e a_dir, b_dir;

    assign a_c   = in_hi;
    assign b_c   = in_lo;
    assign a_dir = route_e'(a_c.tag[STG]);
    assign b_dir = route_e'(b_c.tag[STG]);

    always_comb begin
        oh_c = '0;
        ol_c = '0;
        drop = 1'b0;
        if (a_c.vld) begin
            if (a_dir == ROUTE_LOWER) ol_c = a_c;
            else                      oh_c = a_c;
        end
        if (b_c.vld) begin
            if (a_c.vld && (a_dir == b_dir)) drop = 1'b1;   // upper input wins
            else if (b_dir == ROUTE_LOWER)   ol_c = b_c;
            else                             oh_c = b_c;
        end
    end

    assign out_hi = oh_c;
    assign out_lo = ol_c;

endmodule

// File: rtl/fab_stage.sv
module fab_stage #(
    parameter int unsigned N   = 8,
    parameter int unsigned AW  = 3,
    parameter int unsigned PW  = 8,
    parameter int unsigned STG = 0,
    parameter int unsigned DW  = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N-1:0][2*AW+PW:0]     in_cells,
    output logic [N-1:0][2*AW+PW:0]     out_cells,
    output logic [DW-1:0]               drop_num
);
    localparam int unsigned HALF = N / 2;

    logic [N-1:0][2*AW+PW:0] shuf;
    logic [N-1:0][2*AW+PW:0] nxt;
    logic [HALF-1:0]         drop_v;

    for (genvar k = 0; k < N; k++) begin : g_shuf
        assign shuf[k] = in_cells[fab_pkg::shuffle_src(k, AW)];
    end

    for (genvar e = 0; e < HALF; e++) begin : g_elem
        fab_elem #(.AW(AW), .PW(PW), .STG(STG)) u_elem (
            .in_hi (shuf[2*e]),
            .in_lo (shuf[2*e+1]),
            .out_hi(nxt[2*e]),
            .out_lo(nxt[2*e+1]),
            .drop  (drop_v[e])
        );
    end

    assign drop_num = DW'($countones(drop_v));

    always_ff @(posedge clk) begin
        if (rst) out_cells <= '0;
        else     out_cells <= nxt;
    end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
    parameter int unsigned N     = fab_pkg::FAB_PORTS_DEF,
    parameter int unsigned PW    = fab_pkg::FAB_PAY_DEF,
    parameter int unsigned CNT_W = fab_pkg::FAB_CNT_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N-1:0]            in_valid,
    input  logic [N*$clog2(N)-1:0]  in_dest,
    input  logic [N*PW-1:0]         in_payload,
    output logic [N-1:0]            out_valid,
    output logic [N*$clog2(N)-1:0]  out_dest,
    output logic [N*PW-1:0]         out_payload,
    output logic [CNT_W-1:0]        drop_count
);
    localparam int unsigned AW     = $clog2(N);
    localparam int unsigned CELL_W = 1 + 2*AW + PW;
    localparam int unsigned DW     = $clog2(N/2 + 1);
    localparam int unsigned EXT_W  = CNT_W + AW + DW + 1;
    localparam logic [EXT_W-1:0] CNT_MAX = (EXT_W'(1) << CNT_W) - EXT_W'(1);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] tag;
        logic [AW-1:0] dest;
        logic [PW-1:0] pay;
    } cell_t;

    cell_t                       ing [N];
    logic [AW:0][N-1:0][CELL_W-1:0] pipe;
    logic [AW-1:0][DW-1:0]       dnum;
    logic [EXT_W-1:0]            drop_sum, cnt_next;
    logic [CNT_W-1:0]            cnt_q;

    // Ingress: build cells, routing tag is the bit-reversed destination
    always_comb begin
        for (int p = 0; p < N; p++) begin
            ing[p].vld  = in_valid[p];
            ing[p].dest = in_dest[p*AW +: AW];
            ing[p].pay  = in_payload[p*PW +: PW];
            for (int b = 0; b < AW; b++)
                ing[p].tag[b] = in_dest[p*AW + AW - 1 - b];
        end
    end

    for (genvar p = 0; p < N; p++) begin : g_ing
        assign pipe[0][p] = ing[p];
    end

    for (genvar s = 0; s < AW; s++) begin : g_stage
        fab_stage #(.N(N), .AW(AW), .PW(PW), .STG(s), .DW(DW)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_cells (pipe[s]),
            .out_cells(pipe[s+1]),
            .drop_num (dnum[s])
        );
    end

    // Saturating drop counter
    always_comb begin
        drop_sum = '0;
        for (int s = 0; s < AW; s++)
            drop_sum = drop_sum + EXT_W'(dnum[s]);
        cnt_next = EXT_W'(cnt_q) + drop_sum;
    end

    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (cnt_next > CNT_MAX) cnt_q <= CNT_MAX[CNT_W-1:0];
        else                        cnt_q <= cnt_next[CNT_W-1:0];
    end

    assign drop_count = cnt_q;

    // Egress
    for (genvar k = 0; k < N; k++) begin : g_egr
        cell_t egr;
        assign egr                       = pipe[AW][k];
        assign out_valid[k]              = egr.vld;
        assign out_dest[k*AW +: AW]      = egr.dest;
        assign out_payload[k*PW +: PW]   = egr.pay;
    end

endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
    parameter int unsigned N     = 8,
    parameter int unsigned PW    = 8,
    parameter int unsigned CNT_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N-1:0]           out_valid,
    input logic [N*$clog2(N)-1:0] out_dest,
    input logic [CNT_W-1:0]       drop_count
);
    localparam int unsigned AW      = $clog2(N);
    localparam int unsigned STEP_MX = (N/2) * AW;
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [AW:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                       since_rst <= '0;
        else if (since_rst < (AW+1)'(AW)) since_rst <= since_rst + 1'b1;
    end

    AST_PIPE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (since_rst < (AW+1)'(AW)) |-> (out_valid == '0));   // R1

    for (genvar k = 0; k < N; k++) begin : g_dst
        AST_DEST_MATCH: assert property (@(posedge clk) disable iff (rst)
            out_valid[k] |-> (out_dest[k*AW +: AW] == AW'(k)));   // R3
    end

    AST_DROP_MONO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count >= $past(drop_count)));   // R6

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((32'(drop_count) - 32'($past(drop_count))) <= STEP_MX));   // R6

    AST_DROP_SAT: assert property (@(posedge clk) disable iff (rst)
        (drop_count == SAT) |=> (drop_count == SAT));   // R7

endmodule

bind omega_fabric omega_fabric_chk #(.N(N), .PW(PW), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_dest  (out_dest),
    .drop_count(drop_count)
);

// File: tb/omega_fabric_tb_top.sv
module omega_fabric_tb_top;
    localparam int N     = 8;
    localparam int AW    = 3;
    localparam int PW    = 8;
    localparam int CNT_W = 4;
    localparam int CLK_P = 10;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [N-1:0]        in_valid = '0;
    logic [N*AW-1:0]     in_dest = '0;
    logic [N*PW-1:0]     in_payload = '0;
    logic [N-1:0]        out_valid;
    logic [N*AW-1:0]     out_dest;
    logic [N*PW-1:0]     out_payload;
    logic [CNT_W-1:0]    drop_count;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int seq    = 0;
    bit done   = 0;
    int q_cyc [N][$];
    int q_pay [N][$];

    omega_fabric #(.N(N), .PW(PW), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest),
        .in_payload(in_payload), .out_valid(out_valid), .out_dest(out_dest),
        .out_payload(out_payload), .drop_count(drop_count)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: offer one slot, push expected deliveries for inputs in em
    task automatic offer(input logic [N-1:0] vm, input int dst[N], input logic [N-1:0] em);
        for (int i = 0; i < N; i++) begin
            int pay;
            pay = seq & 8'hFF;
            seq++;
            in_valid[i]            = vm[i];
            in_dest[i*AW +: AW]    = AW'(dst[i]);
            in_payload[i*PW +: PW] = PW'(pay);
            if (vm[i] && em[i]) begin
                q_cyc[dst[i]].push_back(cyc + AW);
                q_pay[dst[i]].push_back(pay);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = '0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare deliveries against the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int k = 0; k < N; k++) begin
                if (out_valid[k]) begin
                    if (q_cyc[k].size() == 0) begin
                        chk(0, "R3/R8 unexpected cell on output", k, -1);
                    end else begin
                        int ec, ep;
                        ec = q_cyc[k].pop_front();
                        ep = q_pay[k].pop_front();
                        chk(cyc == ec, "R2 delivery slot", cyc, ec);
                        chk(int'(out_payload[k*PW +: PW]) == ep, "R3 payload", int'(out_payload[k*PW +: PW]), ep);
                        chk(int'(out_dest[k*AW +: AW]) == k, "R3 dest field", int'(out_dest[k*AW +: AW]), k);
                    end
                end else if (q_cyc[k].size() != 0 && q_cyc[k][0] <= cyc) begin
                    chk(0, "R4/R5 expected cell missing on output", k, q_pay[k][0]);
                    void'(q_cyc[k].pop_front());
                    void'(q_pay[k].pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int d[N];
        int base;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(drop_count == 0, "R1 drop_count in reset", int'(drop_count), 0);
        rst = 1'b0;
        idle(2);
        chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);

        // R2/R3: single cells from every input to every output, back to back
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                for (int i = 0; i < N; i++) d[i] = t;
                offer(N'(1) << s, d, '1);
            end
        end
        idle(5);
        chk(drop_count == 0, "R3 no drops for single cells", int'(drop_count), 0);

        // R4: full-rate cyclic shifts
        for (int c = 0; c < N; c++) begin
            for (int i = 0; i < N; i++) d[i] = (i + c) % N;
            offer('1, d, '1);
            offer('1, d, '1);
        end
        idle(5);
        chk(drop_count == 0, "R4 shifts lose nothing", int'(drop_count), 0);

        // R8: invalid inputs with colliding destinations have no effect
        for (int i = 0; i < N; i++) d[i] = 0;
        offer('0, d, '0);
        offer('0, d, '0);
        idle(5);
        chk(drop_count == 0, "R8 invalid inputs cause no drop", int'(drop_count), 0);
        chk(out_valid == '0, "R8 invalid inputs give no output", int'(out_valid), 0);

        // R5/R9: inputs 0 and 4 meet in column 0; dests 0 and 3 share MSB 0
        for (int i = 0; i < N; i++) d[i] = 0;
        d[4] = 3;
        offer(8'h11, d, 8'h01);
        idle(5);
        chk(drop_count == 1, "R9 collision on shared tag bit 0", int'(drop_count), 1);
        // dests 0 and 4 differ in MSB: both pass
        d[0] = 0; d[4] = 4;
        offer(8'h11, d, 8'h11);
        idle(5);
        chk(drop_count == 1, "R9 distinct tag bit 0 passes both", int'(drop_count), 1);
        // both to 5: lower element output, upper input (input 0) wins
        d[0] = 5; d[4] = 5;
        offer(8'h11, d, 8'h01);
        idle(5);
        chk(drop_count == 2, "R5 upper input wins, one drop", int'(drop_count), 2);

        // R6: all inputs to output 0 in one slot: 7 drops, input 0 delivered
        for (int i = 0; i < N; i++) d[i] = 0;
        offer('1, d, 8'h01);
        idle(5);
        chk(drop_count == 9, "R6 drops summed over columns", int'(drop_count), 9);

        // R7: saturation
        offer('1, d, 8'h01);
        offer('1, d, 8'h01);
        offer('1, d, 8'h01);
        idle(5);
        chk(drop_count == 15, "R7 counter saturates", int'(drop_count), 15);
        offer('1, d, 8'h01);
        idle(5);
        chk(drop_count == 15, "R7 counter holds at max", int'(drop_count), 15);

        // scoreboard drained
        base = 0;
        for (int k = 0; k < N; k++) base += q_cyc[k].size();
        chk(base == 0, "R2 all expected cells seen", base, 0);

        // R1: reset clears the counter
        rst = 1'b1;
        @(negedge clk);
        chk(drop_count == 0, "R1 reset clears drop_count", int'(drop_count), 0);
        finish_run();
    end

endmodule